// File: doc/BRIEF.md
# Combined Serial/Deserial SPI Master

This block is an SPI master that carries two kinds of frame over one serial link. A deserial frame serializes the current value of a parallel input word. The slave's reply to that frame lands on a parallel output word. A command frame takes its payload from a transmit FIFO, and the slave's reply to it is queued in a receive FIFO. Each kind of frame asserts its own chip select, so the slave can tell them apart.

An arbiter picks the next frame only while the shifter is idle. A pending command always wins, and deserial traffic resumes once the transmit FIFO has drained. A deserial frame is sent only when the parallel input differs from the last value that was serialized. Shape and speed come from a bank of attribute registers, each giving frame length, SCK divider, clock polarity and clock phase. A command frame names its attribute register in its own FIFO entry. Deserial frames use the register named by a static selector input.

Top module: `csi_spi_master`

## Requirements
- R1: After reset both chip selects are high, `sck` and `sout` are low, `par_out` is zero, the receive FIFO is empty, `tx_full` and `rx_ovf` are low, and every attribute register holds zero.
- R2: When the shifter is idle and the transmit FIFO is not empty, the next frame is a command frame, even if the parallel input has changed.
- R3: When the shifter is idle and the transmit FIFO is empty, a deserial frame starts if and only if `par_in` differs from the last value serialized (zero after reset). A steady `par_in` sends nothing.
- R4: `cs_spi_n` is low exactly while a command frame is shifting, and `cs_deser_n` exactly while a deserial frame is shifting. Both are high for at least one cycle between frames.
- R5: The word received in a deserial frame is written to `par_out` when the frame ends. The word received in a command frame is pushed into the receive FIFO and leaves `par_out` unchanged.
- R6: A command frame uses the attribute register selected by `tx_wdata[17:16]`, with payload `tx_wdata[15:0]`. A deserial frame uses the register selected by `deser_sel`.
- R7: Attribute word layout: bit 13 is CPOL, bit 12 is CPHA, bits 11:4 are divider D, and bits 3:0 are frame length minus one. Length fields below 3 mean 4 bits. Each SCK half period lasts D+1 clocks.
- R8: A frame of N bits asserts its chip select for (2N+1)(D+1) cycles. There is one half period at idle level CPOL, then 2N SCK edges, then one trailing half period. Data goes out MSB first. With CPHA=0, `sin` is sampled on the 1st, 3rd, ... edges. With CPHA=1 it is sampled on the 2nd, 4th, ... edges, and `sout` advances on the other edges. While idle, `sck` holds the CPOL of the last frame.
- R9: A frame in progress is never interrupted. New FIFO entries or input changes are acted on only at the next frame boundary.
- R10: The transmit FIFO holds 4 entries. `tx_full` is high when it holds 4, and a write while full is dropped.
- R11: The receive FIFO holds 4 words and shows its oldest word on `rx_rdata`. `rx_rd` removes that word. A push while full is dropped and sets `rx_ovf`, which stays high until reset.
- R12: For N below 16, the received word is right-aligned and zero-extended in bits 15:N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| par_in | input | 16 | Parallel word to serialize in deserial frames |
| deser_sel | input | 2 | Attribute register used by deserial frames |
| par_out | output | 16 | Word received in the last deserial frame |
| attr_wr | input | 1 | Attribute register write strobe |
| attr_idx | input | 2 | Attribute register written |
| attr_wdata | input | 14 | Attribute word: CPOL, CPHA, divider, length-1 |
| tx_wr | input | 1 | Transmit FIFO write strobe |
| tx_wdata | input | 18 | Attribute selector (17:16) and payload (15:0) |
| tx_full | output | 1 | Transmit FIFO holds 4 entries |
| rx_rd | input | 1 | Remove the head of the receive FIFO |
| rx_rdata | output | 16 | Head of the receive FIFO |
| rx_empty | output | 1 | Receive FIFO is empty |
| rx_ovf | output | 1 | Sticky receive overflow |
| sck | output | 1 | Serial clock |
| sout | output | 1 | Serial data out |
| sin | input | 1 | Serial data in |
| cs_deser_n | output | 1 | Active-low select for deserial frames |
| cs_spi_n | output | 1 | Active-low select for command frames |

## Verification
The hardest situation to reach is the frame boundary where a queued command and a changed parallel input compete. Priority is only visible if both are pending in the same idle cycle. The stimulus gets there by starting a long deserial frame first. While that frame shifts, it writes a command and changes `par_in` again, so both requests are waiting when the frame ends. The same long-frame window is used to fill the transmit FIFO past its depth. The four queued commands are then left to run until the receive FIFO is full, and one more command is sent to force the overflow.

// File: rtl/csi_pkg.sv
package csi_pkg;

   localparam int FRAME_W = 16;
   localparam int LEN_W   = $clog2(FRAME_W);
   localparam int DIV_W   = 8;
   localparam int ATTR_W  = 2 + DIV_W + LEN_W;
   localparam int MIN_LEN_M1 = 3;

   typedef struct packed {
      logic             cpol;
      logic             cpha;
      logic [DIV_W-1:0] div;
      logic [LEN_W-1:0] len_m1;
   } attr_t;

   function automatic logic [LEN_W-1:0] eff_len_m1(input logic [LEN_W-1:0] f);
      return (f < LEN_W'(MIN_LEN_M1)) ? LEN_W'(MIN_LEN_M1) : f;
   endfunction

endpackage

// File: rtl/csi_fifo.sv
module csi_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         rd,
   output logic [W-1:0] rdata,
   output logic         full,
   output logic         empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_depth_bad
      $error("csi_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp_q, rp_q;
   logic [CW-1:0] cnt_q;
   logic          do_wr, do_rd;

   assign full  = (cnt_q == CW'(DEPTH));
   assign empty = (cnt_q == '0);
   assign do_wr = wr && !full;
   assign do_rd = rd && !empty;
   assign rdata = mem[rp_q];

   always_ff @(posedge clk) begin
      if (do_wr) mem[wp_q] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_wr) wp_q <= wp_q + AW'(1);
         if (do_rd) rp_q <= rp_q + AW'(1);
         case ({do_wr, do_rd})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   // R10 R11
   drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && full && !rd) |=> full);

   // R11
   read_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && empty && !wr) |=> empty);

endmodule

// File: rtl/csi_shift_engine.sv
module csi_shift_engine
   import csi_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FRAME_W-1:0] start_data,
   input  attr_t              start_attr,
   input  logic               sin,
   output logic               busy,
   output logic               done,
   output logic [FRAME_W-1:0] rx_word,
   output logic               sck,
   output logic               sout
);
   localparam int HW = LEN_W + 2;

   logic               busy_q, cpol_q, cpha_q;
   logic [HW-1:0]      h_q;
   logic [DIV_W-1:0]   tmr_q, div_q;
   logic [LEN_W:0]     n_q;
   logic [FRAME_W-1:0] txsh_q, rxsh_q;
   logic               tick, last, edge_evt, do_sample, do_shift;
   logic [LEN_W-1:0]   len_e;

   assign len_e     = eff_len_m1(start_attr.len_m1);
   assign tick      = busy_q && (tmr_q == '0);
   assign last      = (h_q == {n_q, 1'b0});
   assign done      = tick && last;
   assign edge_evt  = tick && !last;
   assign do_sample = edge_evt && (cpha_q ? h_q[0] : !h_q[0]);
   assign do_shift  = edge_evt && (cpha_q ? (!h_q[0] && h_q != '0) : h_q[0]);

   assign busy    = busy_q;
   assign rx_word = rxsh_q;
   assign sck     = busy_q ? (cpol_q ^ h_q[0]) : cpol_q;
   assign sout    = busy_q && txsh_q[FRAME_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cpol_q <= 1'b0;
         cpha_q <= 1'b0;
         h_q    <= '0;
         tmr_q  <= '0;
         div_q  <= '0;
         n_q    <= '0;
         txsh_q <= '0;
         rxsh_q <= '0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q <= 1'b1;
            cpol_q <= start_attr.cpol;
            cpha_q <= start_attr.cpha;
            div_q  <= start_attr.div;
            tmr_q  <= start_attr.div;
            n_q    <= {1'b0, len_e} + {{LEN_W{1'b0}}, 1'b1};
            h_q    <= '0;
            txsh_q <= start_data << (LEN_W'(FRAME_W - 1) - len_e);
            rxsh_q <= '0;
         end
      end else if (tick) begin
         tmr_q <= div_q;
         if (last) busy_q <= 1'b0;
         else      h_q    <= h_q + HW'(1);
         if (do_sample) rxsh_q <= {rxsh_q[FRAME_W-2:0], sin};
         if (do_shift)  txsh_q <= {txsh_q[FRAME_W-2:0], 1'b0};
      end else begin
         tmr_q <= tmr_q - DIV_W'(1);
      end
   end

   // R9
   frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !done) |=> busy_q);

   // R8
   sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && tmr_q != '0) |=> $stable(sck));

endmodule

// File: rtl/csi_spi_master.sv
module csi_spi_master
   import csi_pkg::*;
#(
   parameter  int N_ATTR   = 4,
   parameter  int TX_DEPTH = 4,
   parameter  int RX_DEPTH = 4,
   localparam int SEL_W    = $clog2(N_ATTR),
   localparam int TXW      = SEL_W + FRAME_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FRAME_W-1:0] par_in,
   input  logic [SEL_W-1:0]   deser_sel,
   output logic [FRAME_W-1:0] par_out,
   input  logic               attr_wr,
   input  logic [SEL_W-1:0]   attr_idx,
   input  logic [ATTR_W-1:0]  attr_wdata,
   input  logic               tx_wr,
   input  logic [TXW-1:0]     tx_wdata,
   output logic               tx_full,
   input  logic               rx_rd,
   output logic [FRAME_W-1:0] rx_rdata,
   output logic               rx_empty,
   output logic               rx_ovf,
   output logic               sck,
   output logic               sout,
   input  logic               sin,
   output logic               cs_deser_n,
   output logic               cs_spi_n
);

   if (N_ATTR < 2 || (N_ATTR & (N_ATTR - 1)) != 0) begin : g_attr_bad
      $error("csi_spi_master: N_ATTR must be a power of two, at least 2");
   end

   attr_t              bank [N_ATTR];
   logic [TXW-1:0]     tx_rdata;
   logic               tx_empty, rx_full;
   logic               eng_busy, eng_done, eng_start;
   logic [FRAME_W-1:0] eng_rx, eng_data;
   attr_t              eng_attr;
   logic               pick_spi, pick_des, rx_push;
   logic [FRAME_W-1:0] last_q;
   logic               is_spi_q, ovf_q;

   for (genvar i = 0; i < N_ATTR; i++) begin : g_attr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   bank[i] <= '0;
         else if (attr_wr && attr_idx == SEL_W'(i))    bank[i] <= attr_t'(attr_wdata);
      end
   end

   always_comb begin
      pick_spi  = !eng_busy && !tx_empty;
      pick_des  = !eng_busy && tx_empty && (par_in != last_q);
      eng_start = pick_spi || pick_des;
      eng_data  = pick_spi ? tx_rdata[FRAME_W-1:0] : par_in;
      eng_attr  = bank[pick_spi ? tx_rdata[TXW-1 -: SEL_W] : deser_sel];
   end

   assign rx_push = eng_done && is_spi_q;

   csi_fifo #(.W(TXW), .DEPTH(TX_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n),
      .wr(tx_wr), .wdata(tx_wdata),
      .rd(pick_spi), .rdata(tx_rdata),
      .full(tx_full), .empty(tx_empty)
   );

   csi_fifo #(.W(FRAME_W), .DEPTH(RX_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n),
      .wr(rx_push), .wdata(eng_rx),
      .rd(rx_rd), .rdata(rx_rdata),
      .full(rx_full), .empty(rx_empty)
   );

   csi_shift_engine u_eng (
      .clk(clk), .rst_n(rst_n),
      .start(eng_start), .start_data(eng_data), .start_attr(eng_attr),
      .sin(sin), .busy(eng_busy), .done(eng_done), .rx_word(eng_rx),
      .sck(sck), .sout(sout)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q   <= '0;
         is_spi_q <= 1'b0;
         par_out  <= '0;
         ovf_q    <= 1'b0;
      end else begin
         if (pick_des)                par_out <= par_out;
         if (pick_des)                last_q  <= par_in;
         if (eng_start)               is_spi_q <= pick_spi;
         if (eng_done && !is_spi_q)   par_out <= eng_rx;
         if (rx_push && rx_full)      ovf_q   <= 1'b1;
      end
   end

   assign rx_ovf     = ovf_q;
   assign cs_spi_n   = !(eng_busy && is_spi_q);
   assign cs_deser_n = !(eng_busy && !is_spi_q);

   // R2
   spi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!eng_busy && !tx_empty) |=> !cs_spi_n);

   // R3
   deser_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!eng_busy && tx_empty && par_in != last_q) |=> !cs_deser_n);

   // R5
   par_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(eng_done && !is_spi_q) |=> $stable(par_out));

   // R11
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ovf |=> rx_ovf);

endmodule

// File: tb/csi_spi_master_tb.sv
module csi_spi_master_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] par_in = '0;
   logic [1:0]  deser_sel = '0;
   logic [15:0] par_out;
   logic        attr_wr = 1'b0;
   logic [1:0]  attr_idx = '0;
   logic [13:0] attr_wdata = '0;
   logic        tx_wr = 1'b0;
   logic [17:0] tx_wdata = '0;
   logic        tx_full;
   logic        rx_rd = 1'b0;
   logic [15:0] rx_rdata;
   logic        rx_empty, rx_ovf, sck, sout;
   logic        sin = 1'b0;
   logic        cs_deser_n, cs_spi_n;

   always #4 clk = ~clk;

   csi_spi_master u_dut (
      .clk(clk), .rst_n(rst_n), .par_in(par_in), .deser_sel(deser_sel),
      .par_out(par_out), .attr_wr(attr_wr), .attr_idx(attr_idx),
      .attr_wdata(attr_wdata), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
      .tx_full(tx_full), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
      .rx_empty(rx_empty), .rx_ovf(rx_ovf), .sck(sck), .sout(sout),
      .sin(sin), .cs_deser_n(cs_deser_n), .cs_spi_n(cs_spi_n)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit cmp_en  = 0;
   int cycles  = 0;

   // reference model state
   int m_busy, m_h, m_tmr, m_n, m_div, m_pol, m_pha, m_spi;
   int m_txsh, m_rxsh, m_scnt, m_reply, m_last, m_parout, m_ovf;
   int txq[$];
   int rxq[$];
   int attrm[4];
   int slave_reply = 0;
   int pre_busy, txn, rxn, done, k, e;

   task automatic chk(string tag, string what, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic start_frame(int s, int d, int a);
      int len;
      len = a & 15;
      if (len < 3) len = 3;
      m_n = len + 1;
      m_div = (a >> 4) & 255;
      m_pha = (a >> 12) & 1;
      m_pol = (a >> 13) & 1;
      m_txsh = (d << (16 - m_n)) & 'hFFFF;
      m_rxsh = 0; m_scnt = 0; m_h = 0; m_tmr = m_div;
      m_busy = 1; m_spi = s; m_reply = slave_reply;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_h = 0; m_tmr = 0; m_n = 0; m_div = 0; m_pol = 0; m_pha = 0;
         m_spi = 0; m_txsh = 0; m_rxsh = 0; m_scnt = 0; m_reply = 0; m_last = 0;
         m_parout = 0; m_ovf = 0; txq.delete(); rxq.delete();
         foreach (attrm[i]) attrm[i] = 0;
      end else begin
         pre_busy = m_busy; txn = txq.size(); rxn = rxq.size(); done = 0;
         if (m_busy != 0) begin
            if (m_tmr == 0) begin
               if (m_h == 2 * m_n) done = 1;
               else begin
                  k = m_h;
                  if (m_pha != 0 ? (k % 2 == 1) : (k % 2 == 0)) begin
                     m_rxsh = ((m_rxsh << 1) | int'(sin)) & 'hFFFF;
                     m_scnt++;
                  end
                  if (m_pha != 0 ? (k % 2 == 0 && k > 0) : (k % 2 == 1))
                     m_txsh = (m_txsh << 1) & 'hFFFF;
                  m_h++;
               end
               m_tmr = m_div;
            end else m_tmr--;
         end
         if (done != 0) begin
            m_busy = 0;
            if (m_spi != 0) begin
               if (rxn == 4) m_ovf = 1;
            end else m_parout = m_rxsh;
         end
         if (rx_rd && rxn > 0) void'(rxq.pop_front());
         if (done != 0 && m_spi != 0 && rxn < 4) rxq.push_back(m_rxsh);
         if (pre_busy == 0) begin
            if (txn > 0) begin
               e = txq.pop_front();
               start_frame(1, e & 'hFFFF, attrm[e >> 16]);
            end else if (int'(par_in) != m_last) begin
               m_last = int'(par_in);
               start_frame(0, int'(par_in), attrm[deser_sel]);
            end
         end
         if (tx_wr && txn < 4) txq.push_back(int'(tx_wdata));
         if (attr_wr) attrm[attr_idx] = int'(attr_wdata);
      end
   end

   // per-clock comparison, then slave drives sin
   always @(negedge clk) begin
      if (cmp_en && rst_n) begin
         chk("R8", "sck", int'(sck), m_busy != 0 ? (m_pol ^ (m_h & 1)) : m_pol);
         chk("R8", "sout", int'(sout), m_busy != 0 ? ((m_txsh >> 15) & 1) : 0);
         chk("R4", "cs_spi_n", int'(cs_spi_n), (m_busy != 0 && m_spi != 0) ? 0 : 1);
         chk("R4", "cs_deser_n", int'(cs_deser_n), (m_busy != 0 && m_spi == 0) ? 0 : 1);
         chk("R5", "par_out", int'(par_out), m_parout);
         chk("R10", "tx_full", int'(tx_full), txq.size() == 4 ? 1 : 0);
         chk("R11", "rx_empty", int'(rx_empty), rxq.size() == 0 ? 1 : 0);
         if (rxq.size() > 0) chk("R11", "rx_rdata", int'(rx_rdata), rxq[0]);
         chk("R11", "rx_ovf", int'(rx_ovf), m_ovf);
      end
      if (m_busy != 0 && m_scnt < m_n) sin <= 1'((m_reply >> (m_n - 1 - m_scnt)) & 1);
      else sin <= 1'b0;
   end

   task automatic finish_run();
      $display("[TB]   %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         finish_run();
      end
   end

   task automatic tick(); @(negedge clk); endtask

   task automatic write_attr(int idx, int val);
      attr_wr = 1'b1; attr_idx = 2'(idx); attr_wdata = 14'(val);
      tick();
      attr_wr = 1'b0;
   endtask

   task automatic push_tx(int sel, int data);
      tx_wr = 1'b1; tx_wdata = {2'(sel), 16'(data)};
      tick();
      tx_wr = 1'b0;
   endtask

   task automatic pop_rx();
      rx_rd = 1'b1; tick(); rx_rd = 1'b0;
   endtask

   task automatic wait_idle();
      do tick(); while (m_busy != 0 || txq.size() != 0 || int'(par_in) != m_last);
      tick();
   endtask

   task automatic measure(output int len, output int is_spi);
      while (!cs_spi_n || !cs_deser_n) tick();
      while (cs_spi_n && cs_deser_n) tick();
      is_spi = cs_spi_n ? 0 : 1;
      len = 0;
      while (!cs_spi_n || !cs_deser_n) begin len++; tick(); end
   endtask

   initial begin
      int len, spi, cnt;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1", "cs_spi_n", int'(cs_spi_n), 1);
      chk("R1", "cs_deser_n", int'(cs_deser_n), 1);
      chk("R1", "sck", int'(sck), 0);
      chk("R1", "sout", int'(sout), 0);
      chk("R1", "par_out", int'(par_out), 0);
      chk("R1", "rx_empty", int'(rx_empty), 1);
      chk("R1", "tx_full", int'(tx_full), 0);
      chk("R1", "rx_ovf", int'(rx_ovf), 0);
      cmp_en = 1;

      write_attr(0, 'h0017);   // mode 0, 8 bits, D=1
      write_attr(1, 'h300F);   // CPOL=1 CPHA=1, 16 bits, D=0
      write_attr(2, 'h1024);   // CPHA=1, 5 bits, D=2
      write_attr(3, 'h2001);   // CPOL=1, length field 1 -> 4 bits, D=0
      deser_sel = 2'd2;

      // R3 R6 R7: deserial frame using deser_sel
      slave_reply = 'h001A;
      par_in = 16'h0015;
      measure(len, spi);
      chk("R3", "frame is deserial", spi, 0);
      chk("R6", "deserial length (N5 D2)", len, 33);
      wait_idle();
      chk("R5", "par_out after deserial", int'(par_out), 'h1A);
      chk("R5", "rx fifo untouched", int'(rx_empty), 1);

      // R5 R6 R7: command frame with selector 0
      slave_reply = 'h00C3;
      push_tx(0, 'h00A5);
      measure(len, spi);
      chk("R6", "command frame type", spi, 1);
      chk("R7", "command length (N8 D1)", len, 34);
      wait_idle();
      chk("R5", "rx head after command", int'(rx_rdata), 'hC3);
      chk("R5", "par_out unchanged by command", int'(par_out), 'h1A);
      pop_rx();

      // R7 R12: short length field clamps to 4 bits, reply zero-extended
      slave_reply = 'hFFF9;
      push_tx(3, 'h000B);
      measure(len, spi);
      chk("R7", "clamped length (N4 D0)", len, 9);
      wait_idle();
      chk("R12", "right-aligned 4-bit word", int'(rx_rdata), 'h0009);
      pop_rx();

      // R2 R9: command and new input both pending at a boundary
      deser_sel = 2'd1;
      slave_reply = 'h5A5A;
      par_in = 16'h1234;
      tick();
      push_tx(0, 'h0077);
      par_in = 16'h4321;
      chk("R9", "deserial frame still running", int'(cs_deser_n), 0);
      measure(len, spi);
      chk("R2", "command wins boundary", spi, 1);
      chk("R7", "command length", len, 34);
      measure(len, spi);
      chk("R3", "deserial resumes", spi, 0);
      chk("R8", "16-bit frame length", len, 33);
      wait_idle();
      chk("R5", "par_out after resume", int'(par_out), 'h5A5A);
      chk("R12", "8-bit command reply", int'(rx_rdata), 'h005A);
      pop_rx();

      // R3: steady input sends nothing
      cnt = 0;
      for (int i = 0; i < 40; i++) begin
         tick();
         if (!cs_deser_n || !cs_spi_n) cnt++;
      end
      chk("R3", "no frame with steady input", cnt, 0);

      // R10 R11: fill transmit FIFO during a long frame, then overflow rx
      slave_reply = 'h0081;
      par_in = 16'hFFFF;
      tick();
      for (int i = 0; i < 4; i++) push_tx(0, 'h0010 + i);
      chk("R10", "tx_full after 4 writes", int'(tx_full), 1);
      push_tx(0, 'h00EE);
      chk("R10", "tx_full after dropped write", int'(tx_full), 1);
      wait_idle();
      chk("R11", "no overflow at 4 entries", int'(rx_ovf), 0);
      chk("R10", "fifo holds replies", int'(rx_empty), 0);
      push_tx(0, 'h0055);
      wait_idle();
      chk("R11", "overflow flag set", int'(rx_ovf), 1);
      for (int i = 0; i < 4; i++) begin
         chk("R11", "rx entry", int'(rx_rdata), 'h81);
         pop_rx();
      end
      chk("R11", "rx empty after 4 reads", int'(rx_empty), 1);
      chk("R11", "overflow stays set", int'(rx_ovf), 1);

      repeat (5) tick();
      finish_run();
   end

endmodule